// File: doc/BRIEF.md
# Execute-Stage Operand Forwarding Unit

This block decides, for the instruction sitting in the execute stage of a five-stage in-order pipeline, where each of its two source operands should come from. It compares the two source register indices carried by the execute-stage instruction against the destination indices and write enables of the instructions in the memory and write-back stages. From that comparison it produces one select per operand. The select chooses the value read from the register file during decode, the result held in the memory stage, or the result held in the write-back stage.

The matching is deliberately blind. The unit looks only at the bits in the two source-index positions, so an instruction that has no real source fields, such as an unconditional jump, still receives selects. A consumer that does not use an operand simply ignores its select. The unit also raises a load-stall flag when the memory-stage instruction is a load whose destination is wanted by the execute stage. Such a value is not yet available to forward. A store in execute counts as a reader here, because its data operand sits in the second source field.

The unit is purely combinational. Stall and flush actions, the register file and the operand multiplexers belong to the surrounding pipeline.

Top module: `fwd_unit`

## Requirements
- R1: When neither later stage produces the register an operand reads, that operand's select is 2'b00 (decode-stage register-file value).
- R2: When the memory-stage instruction writes (write enable high) a nonzero destination equal to an operand's source index, that operand's select is 2'b01.
- R3: When only the write-back-stage instruction writes a nonzero destination equal to an operand's source index, that operand's select is 2'b10.
- R4: When both later stages write the same nonzero register that an operand reads, the memory stage wins and the select is 2'b01.
- R5: A stage whose write enable is low is never chosen as a source, even if its destination index matches. This includes a branch in the memory stage.
- R6: Register index 0 is never forwarded: an operand with source index 0 always gets select 2'b00, whatever the later stages hold.
- R7: The two selects are computed independently and from index bits alone. Equal source indices get equal selects, and the type of the execute-stage instruction has no effect.
- R8: The load-stall output is 1 when the memory-stage instruction has its load flag and write enable set, a nonzero destination, and that destination equals either source index of the execute stage. This includes a store's data operand in the second source field.
- R9: The load-stall output is 0 when the memory-stage instruction is not a load, has its write enable low, targets register 0, or matches neither source index.
- R10: A select never takes the unused code 2'b11.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| ex_src_a_i | input | REG_W | First source register index of the execute-stage instruction |
| ex_src_b_i | input | REG_W | Second source register index of the execute-stage instruction |
| mem_dst_i | input | REG_W | Destination register index of the memory-stage instruction |
| mem_wen_i | input | 1 | Register write enable of the memory-stage instruction |
| mem_load_i | input | 1 | Memory-stage instruction writes loaded memory data to its destination |
| wb_dst_i | input | REG_W | Destination register index of the write-back-stage instruction |
| wb_wen_i | input | 1 | Register write enable of the write-back-stage instruction |
| sel_a_o | output | 2 | Source select for the first operand (00 decode, 01 memory, 10 write-back) |
| sel_b_o | output | 2 | Source select for the second operand (00 decode, 01 memory, 10 write-back) |
| load_stall_o | output | 1 | A wanted value is still being loaded in the memory stage |

## Verification
The bench builds the unit with the default REG_W of 5, the full 32-entry register index space. This lets directed cases reach both ends of that space: register 0, which must never forward, and register 31. Its generated stimulus draws indices only from registers 0 to 3. That makes collisions between the execute sources and the two later destinations frequent, so the priority, write-enable gating and zero-register rules are exercised many times over, together with a store whose data operand matches a load in the memory stage.

// File: rtl/fwd_pkg.sv
package fwd_pkg;

    localparam int FWD_SEL_W = 2;

    typedef enum logic [FWD_SEL_W-1:0] {
        FWD_FROM_ID  = 2'b00,
        FWD_FROM_MEM = 2'b01,
        FWD_FROM_WB  = 2'b10
    } fwd_sel_e;

endpackage

// File: rtl/fwd_stage_match.sv
module fwd_stage_match #(
    parameter int REG_W = 5
) (
    input  logic [REG_W-1:0] src_idx_i,
    input  logic [REG_W-1:0] dst_idx_i,
    input  logic             dst_wen_i,
    output logic             hit_o
);

    logic dst_nonzero;

    always_comb begin
        dst_nonzero = (dst_idx_i != '0);
        hit_o       = dst_wen_i && dst_nonzero && (dst_idx_i == src_idx_i);
    end

endmodule

// File: rtl/fwd_operand_pick.sv
module fwd_operand_pick
    import fwd_pkg::*;
#(
    parameter int REG_W = 5
) (
    input  logic [REG_W-1:0] src_idx_i,
    input  logic             mem_hit_i,
    input  logic             wb_hit_i,
    output fwd_sel_e         sel_o
);

    always_comb begin
        unique case ({mem_hit_i, wb_hit_i})
            2'b10, 2'b11: sel_o = FWD_FROM_MEM;
            2'b01:        sel_o = FWD_FROM_WB;
            default:      sel_o = FWD_FROM_ID;
        endcase
    end

    always_comb begin
        AST_SEL_LEGAL: assert (sel_o != fwd_sel_e'(2'b11)) else $error("illegal select code"); // R10
        if (src_idx_i == '0) begin
            AST_ZERO_REG_LOCAL: assert (sel_o == FWD_FROM_ID) else $error("x0 forwarded"); // R6
        end
        if (mem_hit_i) begin
            AST_MEM_WINS: assert (sel_o == FWD_FROM_MEM) else $error("memory stage lost priority"); // R4
        end
    end

endmodule

// File: rtl/fwd_load_detect.sv
module fwd_load_detect #(
    parameter int NUM_SRC = 2
) (
    input  logic               mem_load_i,
    input  logic [NUM_SRC-1:0] src_mem_hit_i,
    output logic               stall_o
);

    always_comb begin
        stall_o = mem_load_i && (|src_mem_hit_i);
    end

    always_comb begin
        if (!mem_load_i) begin
            AST_STALL_NEEDS_LOAD: assert (!stall_o) else $error("stall without load"); // R9
        end
    end

endmodule

// File: rtl/fwd_unit.sv
module fwd_unit
    import fwd_pkg::*;
#(
    parameter int REG_W = 5
) (
    input  logic [REG_W-1:0]     ex_src_a_i,
    input  logic [REG_W-1:0]     ex_src_b_i,
    input  logic [REG_W-1:0]     mem_dst_i,
    input  logic                 mem_wen_i,
    input  logic                 mem_load_i,
    input  logic [REG_W-1:0]     wb_dst_i,
    input  logic                 wb_wen_i,
    output logic [FWD_SEL_W-1:0] sel_a_o,
    output logic [FWD_SEL_W-1:0] sel_b_o,
    output logic                 load_stall_o
);

    localparam int NUM_SRC = 2;

    logic [NUM_SRC-1:0][REG_W-1:0] src_idx;
    logic [NUM_SRC-1:0]            mem_hit;
    logic [NUM_SRC-1:0]            wb_hit;
    fwd_sel_e                      sel   [NUM_SRC];

    assign src_idx[0] = ex_src_a_i;
    assign src_idx[1] = ex_src_b_i;

    for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
        fwd_stage_match #(.REG_W(REG_W)) u_mem_match (
            .src_idx_i (src_idx[g]),
            .dst_idx_i (mem_dst_i),
            .dst_wen_i (mem_wen_i),
            .hit_o     (mem_hit[g])
        );

        fwd_stage_match #(.REG_W(REG_W)) u_wb_match (
            .src_idx_i (src_idx[g]),
            .dst_idx_i (wb_dst_i),
            .dst_wen_i (wb_wen_i),
            .hit_o     (wb_hit[g])
        );

        fwd_operand_pick #(.REG_W(REG_W)) u_pick (
            .src_idx_i (src_idx[g]),
            .mem_hit_i (mem_hit[g]),
            .wb_hit_i  (wb_hit[g]),
            .sel_o     (sel[g])
        );
    end

    fwd_load_detect #(.NUM_SRC(NUM_SRC)) u_load (
        .mem_load_i    (mem_load_i),
        .src_mem_hit_i (mem_hit),
        .stall_o       (load_stall_o)
    );

    assign sel_a_o = sel[0];
    assign sel_b_o = sel[1];

    always_comb begin
        if (!mem_wen_i && !wb_wen_i) begin
            AST_NO_WRITER_NO_FWD: assert (sel_a_o == FWD_FROM_ID && sel_b_o == FWD_FROM_ID)
                else $error("forwarded from a non-writing stage"); // R5
        end
        if (load_stall_o) begin
            AST_STALL_HAS_MEM_SEL: assert (sel_a_o == FWD_FROM_MEM || sel_b_o == FWD_FROM_MEM)
                else $error("stall without a memory-stage match"); // R8
        end
        if (ex_src_a_i == ex_src_b_i) begin
            AST_SAME_SRC_SAME_SEL: assert (sel_a_o == sel_b_o)
                else $error("equal sources got different selects"); // R7
        end
    end

endmodule

// File: tb/fwd_unit_bench.sv
`timescale 1ns/1ps
module fwd_unit_bench;

    localparam int REG_W = 5;

    typedef struct {
        logic [1:0] a;
        logic [1:0] b;
        logic       haz;
        string      tag;
    } exp_t;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #5 clk = ~clk;

    logic [REG_W-1:0] ex_src_a, ex_src_b, mem_dst, wb_dst;
    logic             mem_wen, mem_load, wb_wen;
    logic [1:0]       sel_a, sel_b;
    logic             load_stall;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 1'b0;
    exp_t sb_q[$];

    fwd_unit #(.REG_W(REG_W)) u_fwd_unit (
        .ex_src_a_i   (ex_src_a),
        .ex_src_b_i   (ex_src_b),
        .mem_dst_i    (mem_dst),
        .mem_wen_i    (mem_wen),
        .mem_load_i   (mem_load),
        .wb_dst_i     (wb_dst),
        .wb_wen_i     (wb_wen),
        .sel_a_o      (sel_a),
        .sel_b_o      (sel_b),
        .load_stall_o (load_stall)
    );

    // Expected select from the requirement text: memory first, then write-back, never x0.
    function automatic logic [1:0] want_sel(logic [REG_W-1:0] s, logic [REG_W-1:0] md,
                                            logic mw, logic [REG_W-1:0] wd, logic ww);
        if (s == 0) return 2'b00;
        if (mw && md == s) return 2'b01;
        if (ww && wd == s) return 2'b10;
        return 2'b00;
    endfunction

    task automatic drive(input logic [REG_W-1:0] a, input logic [REG_W-1:0] b,
                         input logic [REG_W-1:0] md, input logic mw, input logic ml,
                         input logic [REG_W-1:0] wd, input logic ww, input string tag);
        exp_t e;
        @(posedge clk);
        #1;
        ex_src_a = a; ex_src_b = b;
        mem_dst = md; mem_wen = mw; mem_load = ml;
        wb_dst = wd; wb_wen = ww;
        e.a   = want_sel(a, md, mw, wd, ww);
        e.b   = want_sel(b, md, mw, wd, ww);
        e.haz = ml && mw && (md != 0) && (md == a || md == b);
        e.tag = tag;
        sb_q.push_back(e);
    endtask

    always @(negedge clk) begin
        if (rst_n && sb_q.size() > 0) begin
            exp_t e;
            e = sb_q.pop_front();
            n_cmp++;
            if (sel_a !== e.a) begin
                n_bad++;
                $display("FAIL %s sel_a actual=%b expected=%b", e.tag, sel_a, e.a);
            end
            n_cmp++;
            if (sel_b !== e.b) begin
                n_bad++;
                $display("FAIL %s sel_b actual=%b expected=%b", e.tag, sel_b, e.b);
            end
            n_cmp++;
            if (load_stall !== e.haz) begin
                n_bad++;
                $display("FAIL %s load_stall actual=%b expected=%b", e.tag, load_stall, e.haz);
            end
            n_cmp++;
            if (sel_a === 2'b11 || sel_b === 2'b11) begin
                n_bad++;
                $display("FAIL R10 unused code actual=%b/%b expected=not 11", sel_a, sel_b);
            end
        end
    end

    initial begin
        ex_src_a = '0; ex_src_b = '0; mem_dst = '0; wb_dst = '0;
        mem_wen = 1'b0; mem_load = 1'b0; wb_wen = 1'b0;
        repeat (3) @(posedge clk);
        rst_n = 1'b1;
        // reset-like idle state
        drive(0, 0, 0, 0, 0, 0, 0, "R1 idle");
        drive(7, 8, 3, 1, 0, 4, 1, "R1 no match");
        // memory-stage branch with matching rd, write-back match on b
        drive(4, 5, 4, 0, 0, 5, 1, "R5 R3 branch in mem");
        // jump in EX with junk source bits, memory writes x1, write-back targets x0
        drive(1, 5, 1, 1, 0, 0, 1, "R2 R7 jump blind");
        // store in EX, load in MEM to another register
        drive(2, 5, 1, 1, 1, 5, 1, "R9 store no match");
        // store data operand matches load destination
        drive(2, 7, 7, 1, 1, 0, 0, "R8 store rs2 vs load");
        drive(7, 2, 7, 1, 1, 0, 0, "R8 load feeds a");
        drive(3, 6, 3, 1, 0, 3, 1, "R4 both stages");
        drive(9, 9, 9, 1, 0, 0, 0, "R7 equal sources");
        drive(0, 0, 0, 1, 1, 0, 1, "R6 R9 x0 load");
        drive(6, 6, 6, 0, 1, 0, 0, "R9 load wen low");
        drive(12, 13, 12, 0, 0, 12, 1, "R5 mem not writing");
        drive(31, 30, 31, 1, 0, 30, 1, "R2 R3 reg 31");
        drive(0, 31, 31, 1, 1, 0, 1, "R6 R8 top index");
        for (int i = 0; i < 300; i++) begin
            drive(REG_W'($urandom_range(0, 3)), REG_W'($urandom_range(0, 3)),
                  REG_W'($urandom_range(0, 3)), 1'($urandom_range(0, 1)),
                  1'($urandom_range(0, 1)), REG_W'($urandom_range(0, 3)),
                  1'($urandom_range(0, 1)), "R4 R5 R6 R8 R9 sweep");
        end
        repeat (3) @(posedge clk);
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        #2000000;
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule